// File: doc/BRIEF.md
# Memory Operand Multiply Sequencer

This block fetches two operands from a single-port memory, multiplies them and writes the product back to the same memory. A one-cycle `start` pulse launches the job. The block first reads the word at `addr_a` into an operand register. It then reads the word at `addr_b` into a second operand register. Next it forms the double-width product in an accumulator, and last it writes that product to `addr_c`. It then raises `done` for one cycle and goes back to idle.

A small state machine drives the datapath. Each state issues one micro-operation, and the state selects a packed control word whose value is fixed for that state. The control word is also exported, so a neighbouring block or a trace can follow the sequence cycle by cycle.

The memory must return read data before the clock edge that closes the cycle in which the address is presented. The operand register captures that data on this edge.

Top module: `mpy_seq`

## Requirements
- R1: Synchronous active-high `rst` returns the sequencer to idle and clears both operand registers and the accumulator. After reset, `busy`, `done` and `ctrl_word` are 0, and `mem_wdata` reads 0.
- R2: In idle, `start` sampled high on a clock edge begins the job, and the next cycle is the first fetch cycle. `start` has no effect while `busy` is high, and the cycle-by-cycle outputs of a running job are unchanged by it.
- R3: In the first fetch cycle, `ctrl_word` is 9'b100100000 and `mem_addr` equals `addr_a`. The low OPW bits of `mem_rdata` are captured into the first operand on the edge that ends this cycle.
- R4: In the second fetch cycle, `ctrl_word` is 9'b010100001 and `mem_addr` equals `addr_b`. The low OPW bits of `mem_rdata` are captured into the second operand on the edge that ends this cycle.
- R5: In the multiply cycle, `ctrl_word` is 9'b001001000, and neither `mem_rd` nor `mem_wr` is high. The accumulator loads the unsigned 2·OPW-bit product of the two operands.
- R6: In the store cycle, `ctrl_word` is 9'b000010010, `mem_addr` equals `addr_c`, and `mem_wr` is high. `mem_wdata` always shows the accumulator: the full product when STORE_FULL=1, or its low OPW bits when STORE_FULL=0.
- R7: After the store cycle comes a single cycle with `done` high, followed by idle. `busy` is high in every cycle except idle. Idle and the done cycle both drive an all-zero `ctrl_word`.
- R8: `mem_rd` and `mem_wr` are never high in the same cycle. `mem_rd` equals `ctrl_word[5]` and `mem_wr` equals `ctrl_word[4]`.
- R9: The control word is laid out from bit 8 down to bit 0 as follows: first-operand load, second-operand load, accumulator load, read, write, ALU select (2 bits, 10 = product), then address select (2 bits: 00 = A, 01 = B, 10 = C). It only ever takes the six per-state values. An undefined state code drives an all-zero word and returns to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, honoured only in idle |
| addr_a | input | AW | Address of the first operand |
| addr_b | input | AW | Address of the second operand |
| addr_c | input | AW | Address that receives the product |
| mem_addr | output | AW | Memory address for the current micro-operation |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable |
| mem_wdata | output | MDW | Write data, taken from the accumulator (MDW = 2·OPW or OPW) |
| mem_rdata | input | MDW | Read data, valid by the edge ending the read cycle |
| done | output | 1 | One-cycle completion flag |
| busy | output | 1 | High whenever the sequencer is not idle |
| ctrl_word | output | 9 | Exported packed control word of the current state |

## Verification
The bench builds the block with OPW=8, AW=5 and STORE_FULL=1, so the memory is 16 bits wide and each operand is drawn from only the low byte of a word. Memory words carry nonzero upper bytes, which exposes any operand capture that is too wide. The 255×255 case reaches the top bit of the 16-bit product, and a 32-word memory allows jobs whose C address overlaps A. The STORE_FULL=0 truncation path is covered by the store-width reasoning in R6, and the bench's expected store value follows the same parameter.

// File: rtl/mpy_seq_pkg.sv
package mpy_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_GET_A = 3'd1,
      ST_GET_B = 3'd2,
      ST_MUL   = 3'd3,
      ST_PUT   = 3'd4,
      ST_FIN   = 3'd5
   } seq_state_e;

   localparam logic [1:0] ASEL_A    = 2'b00;
   localparam logic [1:0] ASEL_B    = 2'b01;
   localparam logic [1:0] ASEL_C    = 2'b10;
   localparam logic [1:0] OSEL_NONE = 2'b00;
   localparam logic [1:0] OSEL_PROD = 2'b10;

   typedef struct packed {
      logic       ld_r0;
      logic       ld_r1;
      logic       ld_acc;
      logic       rd;
      logic       wr;
      logic [1:0] op_sel;
      logic [1:0] adr_sel;
   } uop_t;

   localparam int UOP_W = $bits(uop_t);

endpackage

// File: rtl/mpy_seq_ctrl.sv
module mpy_seq_ctrl
   import mpy_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   output seq_state_e state_o,
   output uop_t       uop_o
);

   seq_state_e st_q;
   seq_state_e st_d;

   // next state: one micro-operation per state, undefined codes fall back to idle
   always_comb begin
      case (st_q)
         ST_IDLE:  st_d = start ? ST_GET_A : ST_IDLE;
         ST_GET_A: st_d = ST_GET_B;
         ST_GET_B: st_d = ST_MUL;
         ST_MUL:   st_d = ST_PUT;
         ST_PUT:   st_d = ST_FIN;
         ST_FIN:   st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_d;
   end

   // control word: every field zero unless the state names it
   always_comb begin
      uop_o = '0;
      case (st_q)
         ST_GET_A: begin
            uop_o.ld_r0   = 1'b1;
            uop_o.rd      = 1'b1;
            uop_o.adr_sel = ASEL_A;
         end
         ST_GET_B: begin
            uop_o.ld_r1   = 1'b1;
            uop_o.rd      = 1'b1;
            uop_o.adr_sel = ASEL_B;
         end
         ST_MUL: begin
            uop_o.ld_acc  = 1'b1;
            uop_o.op_sel  = OSEL_PROD;
         end
         ST_PUT: begin
            uop_o.wr      = 1'b1;
            uop_o.adr_sel = ASEL_C;
         end
         default: uop_o = '0;
      endcase
   end

   assign state_o = st_q;

   p_start_go_r2: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE && start) |=> (st_q == ST_GET_A));

   p_done_once_r7: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_FIN) |=> (st_q == ST_IDLE));

   p_rdwr_excl_r8: assert property (@(posedge clk) disable iff (rst)
      !(uop_o.rd && uop_o.wr));

   p_bad_code_r9: assert property (@(posedge clk) disable iff (rst)
      !(st_q inside {ST_IDLE, ST_GET_A, ST_GET_B, ST_MUL, ST_PUT, ST_FIN})
      |=> (st_q == ST_IDLE));

endmodule

// File: rtl/mpy_seq_dp.sv
module mpy_seq_dp
   import mpy_seq_pkg::*;
#(
   parameter int OPW        = 8,
   parameter int AW         = 6,
   parameter int STORE_FULL = 1,
   localparam int PW        = 2 * OPW,
   localparam int MDW       = (STORE_FULL != 0) ? PW : OPW
) (
   input  logic           clk,
   input  logic           rst,
   input  uop_t           uop_i,
   input  logic [AW-1:0]  addr_a,
   input  logic [AW-1:0]  addr_b,
   input  logic [AW-1:0]  addr_c,
   input  logic [MDW-1:0] rdata_i,
   output logic [AW-1:0]  addr_o,
   output logic [MDW-1:0] wdata_o
);

   logic [OPW-1:0] r0_q;
   logic [OPW-1:0] r1_q;
   logic [PW-1:0]  acc_q;
   logic [PW-1:0]  alu_res;
   logic [OPW-1:0] rd_opnd;

   assign rd_opnd = rdata_i[OPW-1:0];

   always_comb begin
      case (uop_i.op_sel)
         OSEL_PROD: alu_res = PW'(r0_q) * PW'(r1_q);
         default:   alu_res = '0;
      endcase
   end

   always_comb begin
      case (uop_i.adr_sel)
         ASEL_A:  addr_o = addr_a;
         ASEL_B:  addr_o = addr_b;
         ASEL_C:  addr_o = addr_c;
         default: addr_o = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         r0_q  <= '0;
         r1_q  <= '0;
         acc_q <= '0;
      end else begin
         if (uop_i.ld_r0)  r0_q  <= rd_opnd;
         if (uop_i.ld_r1)  r1_q  <= rd_opnd;
         if (uop_i.ld_acc) acc_q <= alu_res;
      end
   end

   generate
      if (STORE_FULL != 0) begin : g_store_full
         assign wdata_o = acc_q;
      end else begin : g_store_trunc
         assign wdata_o = acc_q[OPW-1:0];
      end
   endgenerate

   p_r0_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !uop_i.ld_r0 |=> $stable(r0_q));

   p_r1_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !uop_i.ld_r1 |=> $stable(r1_q));

   p_acc_prod_r5: assert property (@(posedge clk) disable iff (rst)
      (uop_i.ld_acc && uop_i.op_sel == OSEL_PROD)
      |=> (acc_q == $past(PW'(r0_q) * PW'(r1_q))));

endmodule

// File: rtl/mpy_seq.sv
module mpy_seq
   import mpy_seq_pkg::*;
#(
   parameter int OPW        = 8,
   parameter int AW         = 6,
   parameter int STORE_FULL = 1,
   localparam int MDW       = (STORE_FULL != 0) ? 2 * OPW : OPW
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [AW-1:0]    addr_a,
   input  logic [AW-1:0]    addr_b,
   input  logic [AW-1:0]    addr_c,
   output logic [AW-1:0]    mem_addr,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic [MDW-1:0]   mem_wdata,
   input  logic [MDW-1:0]   mem_rdata,
   output logic             done,
   output logic             busy,
   output logic [UOP_W-1:0] ctrl_word
);

   generate
      if (OPW < 2 || OPW > 32) begin : g_bad_opw
         $error("mpy_seq: OPW must lie in 2..32");
      end
      if (AW < 1 || AW > 32) begin : g_bad_aw
         $error("mpy_seq: AW must lie in 1..32");
      end
      if (STORE_FULL != 0 && STORE_FULL != 1) begin : g_bad_sf
         $error("mpy_seq: STORE_FULL must be 0 or 1");
      end
   endgenerate

   seq_state_e state;
   uop_t       uop;

   mpy_seq_ctrl u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .state_o (state),
      .uop_o   (uop)
   );

   mpy_seq_dp #(
      .OPW        (OPW),
      .AW         (AW),
      .STORE_FULL (STORE_FULL)
   ) u_dp (
      .clk     (clk),
      .rst     (rst),
      .uop_i   (uop),
      .addr_a  (addr_a),
      .addr_b  (addr_b),
      .addr_c  (addr_c),
      .rdata_i (mem_rdata),
      .addr_o  (mem_addr),
      .wdata_o (mem_wdata)
   );

   assign mem_rd    = uop.rd;
   assign mem_wr    = uop.wr;
   assign ctrl_word = uop;
   assign done      = (state == ST_FIN);
   assign busy      = (state != ST_IDLE);

   p_wr_after_mul_r6: assert property (@(posedge clk) disable iff (rst)
      mem_wr |-> $past(uop.ld_acc));

   p_done_busy_r7: assert property (@(posedge clk) disable iff (rst)
      done |-> busy);

endmodule

// File: tb/mpy_seq_bench.sv
module mpy_seq_bench;

   localparam int OPW = 8;
   localparam int AW  = 5;
   localparam int SF  = 1;
   localparam int PW  = 2 * OPW;
   localparam int MDW = (SF != 0) ? PW : OPW;
   localparam int DEPTH = 1 << AW;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           start = 1'b0;
   logic [AW-1:0]  addr_a = '0;
   logic [AW-1:0]  addr_b = '0;
   logic [AW-1:0]  addr_c = '0;
   logic [AW-1:0]  mem_addr;
   logic           mem_rd;
   logic           mem_wr;
   logic [MDW-1:0] mem_wdata;
   logic [MDW-1:0] mem_rdata;
   logic           done;
   logic           busy;
   logic [8:0]     ctrl_word;

   logic [MDW-1:0] mem [DEPTH];

   int n_chk  = 0;
   int n_fail = 0;

   // reference model state
   int             ph = 0;
   logic [OPW-1:0] m_r0 = '0;
   logic [OPW-1:0] m_r1 = '0;
   logic [PW-1:0]  m_acc = '0;

   always #5 clk = ~clk;

   mpy_seq #(.OPW(OPW), .AW(AW), .STORE_FULL(SF)) u_mpy_seq (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .addr_a    (addr_a),
      .addr_b    (addr_b),
      .addr_c    (addr_c),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .done      (done),
      .busy      (busy),
      .ctrl_word (ctrl_word)
   );

   assign mem_rdata = mem[mem_addr];

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr] <= mem_wdata;
   end

   function automatic logic [MDW-1:0] store_view(input logic [PW-1:0] p);
      return MDW'(p);
   endfunction

   // expected control word per phase, layout from R9
   function automatic logic [8:0] exp_word(input int p);
      case (p)
         1:       return 9'b100100000;
         2:       return 9'b010100001;
         3:       return 9'b001001000;
         4:       return 9'b000010010;
         default: return 9'b000000000;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         ph    = 0;
         m_r0  = '0;
         m_r1  = '0;
         m_acc = '0;
      end else begin
         case (ph)
            0: if (start) ph = 1;
            1: begin m_r0 = mem[addr_a][OPW-1:0]; ph = 2; end
            2: begin m_r1 = mem[addr_b][OPW-1:0]; ph = 3; end
            3: begin m_acc = PW'(m_r0) * PW'(m_r1); ph = 4; end
            4: ph = 5;
            default: ph = 0;
         endcase
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         chk("R9 ctrl_word", 64'(ctrl_word), 64'(exp_word(ph)));
         chk("R7 busy", 64'(busy), 64'(ph != 0));
         chk("R7 done", 64'(done), 64'(ph == 5));
         chk("R8 mem_rd", 64'(mem_rd), 64'(ph == 1 || ph == 2));
         chk("R8 mem_wr", 64'(mem_wr), 64'(ph == 4));
         chk("R6 mem_wdata", 64'(mem_wdata), 64'(store_view(m_acc)));
         if (ph == 1) chk("R3 mem_addr", 64'(mem_addr), 64'(addr_a));
         if (ph == 2) chk("R4 mem_addr", 64'(mem_addr), 64'(addr_b));
         if (ph == 4) chk("R6 mem_addr", 64'(mem_addr), 64'(addr_c));
         if (ph == 3) chk("R5 no access", 64'({mem_rd, mem_wr}), 64'(0));
      end
   end

   task automatic run_job(input int a, input int b, input int c, input int extra_start_at);
      logic [PW-1:0] want;
      want = PW'(mem[a][OPW-1:0]) * PW'(mem[b][OPW-1:0]);
      @(posedge clk); #1;
      addr_a = AW'(a);
      addr_b = AW'(b);
      addr_c = AW'(c);
      start  = 1'b1;
      @(posedge clk); #1;
      start  = 1'b0;
      for (int k = 1; k < 8; k++) begin
         if (k == extra_start_at) start = 1'b1;
         @(posedge clk); #1;
         start = 1'b0;
      end
      chk("R6 stored word", 64'(mem[c]), 64'(store_view(want)));
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = MDW'(i * 613 + 91);
      mem[30] = MDW'(16'hA5FF);
      mem[31] = MDW'(16'h3CFF);
      mem[7]  = MDW'(16'h7700);
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      chk("R1 busy after reset", 64'(busy), 64'(0));
      chk("R1 ctrl after reset", 64'(ctrl_word), 64'(0));
      chk("R1 acc after reset", 64'(mem_wdata), 64'(0));
      run_job(3, 9, 20, 0);
      run_job(30, 31, 21, 0);
      chk("R5 max product", 64'(mem[21]), 64'(store_view(16'hFE01)));
      run_job(5, 5, 22, 0);
      run_job(7, 12, 23, 0);
      chk("R5 zero operand", 64'(mem[23]), 64'(0));
      run_job(11, 14, 11, 2);
      run_job(2, 4, 24, 4);
      // reset in the middle of a job
      @(posedge clk); #1;
      addr_a = 5'd1; addr_b = 5'd2; addr_c = 5'd25; start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      @(posedge clk); #1;
      @(posedge clk); #1 rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      @(negedge clk);
      chk("R1 busy after mid reset", 64'(busy), 64'(0));
      chk("R1 acc after mid reset", 64'(mem_wdata), 64'(0));
      run_job(17, 19, 26, 0);
      repeat (3) @(posedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule